// File: doc/BRIEF.md
# Lifecycle Escalation Responder

This block holds the lifecycle stage of a device and turns it into a set of enable lines for debug, test, CPU, key and seed-access logic. It also answers a staged escalation network. Three severity lines arrive from an alert-handling unit. The lowest severity is only noted and changes nothing. The middle severity puts the block into an escalate state. In that state the escalate and check-bypass enables are raised and the privileged enables are dropped. The highest severity sends the block to a terminal scrap state. Scrap keeps only the escalate and check-bypass enables alive.

The stage is taken from the `stage_i` input while reset is held. After reset, that input is no longer looked at. Escalate and scrap are sticky: they hold until the next reset, whatever the escalation lines do afterwards. The readable state and the enable vector are both registers. A consumer therefore sees a change right after the clock edge that sampled the escalation input.

Top module: `lc_esc_responder`

## Requirements
- R1: On every rising clock edge with `rst_ni` low, the stage register loads `stage_i` and `en_o` is cleared to all zero. After reset is released, changes on `stage_i` have no effect on `state_o` or `en_o`.
- R2: `state_o` reports the stage, and `en_o` decodes it. The enable bits are: bit0 test, bit1 hardware debug, bit2 non-volatile debug, bit3 CPU, bit4 key manager, bit5 seed read, bit6 escalate, bit7 check-bypass. The stage codes and their enable values are: 0x1 unlocked test → 0x0B, 0x2 development → 0x3E, 0x3 production → 0x38, 0x4 RMA → 0x3F, 0x5 locked test → 0x00.
- R3: Any `stage_i` code other than 0x1 to 0x5 and 0xF, including the escalate code 0xA, is loaded as scrap: `state_o` = 0xF and `en_o` = 0xC0.
- R4: Asserting only `esc_i[0]` (first severity) leaves `state_o` and `en_o` unchanged.
- R5: `esc_i[1]` (second severity) moves `state_o` to 0xA. In that state `en_o` has bit6 and bit7 set, bit3 copied from the loaded stage's CPU enable, and all other bits zero.
- R6: `esc_i[2]` (third severity) moves `state_o` to scrap 0xF with `en_o` = 0xC0, so the CPU enable is off. It wins over `esc_i[1]` in the same cycle. Once in scrap, a later `esc_i[1]` has no effect.
- R7: Escalate and scrap persist after the escalation inputs drop, until reset.
- R8: An escalation input that is high at a rising edge is reflected on `state_o` and `en_o` right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset; the stage is loaded while it is low |
| esc_i | input | 3 | Escalation severities: bit0 first, bit1 second, bit2 third |
| stage_i | input | 4 | Lifecycle stage code, sampled only during reset |
| state_o | output | 4 | Readable lifecycle state code |
| en_o | output | 8 | Decoded enable vector |

## Verification
The bench goes after five corner cases.
- Second and third severity asserted in the same cycle: a design that ranked them wrongly would settle in escalate with the CPU enable still up.
- Escalation lines dropping after escalate or scrap: a non-sticky design would fall back to the stage decode and revive debug and key access.
- Invalid and escalate codes loaded at reset: a design that did not map these to scrap would decode garbage enables.
- `stage_i` moving after reset: a design that kept following it would let an attacker re-select the stage at run time.
- The exact cycle of each change: an unregistered design would show the new state before the sampling edge.

// File: rtl/lc_resp_pkg.sv
// Shared encodings for the lifecycle escalation responder.
// Assumes a 4-bit stage code and an 8-bit enable vector with fixed bit roles.
package lc_resp_pkg;

    localparam int STAGE_W = 4;
    localparam int NUM_EN  = 8;

    // Stage and state codes; escalate and scrap are reported on the state output.
    typedef enum logic [STAGE_W-1:0] {
        ST_TEST_UNLK = 4'h1,
        ST_DEV       = 4'h2,
        ST_PROD      = 4'h3,
        ST_RMA       = 4'h4,
        ST_TEST_LOCK = 4'h5,
        ST_ESCALATE  = 4'hA,
        ST_SCRAP     = 4'hF
    } lc_state_e;

    // Escalation severity held by the tracker.
    typedef enum logic [1:0] {
        SEV_NONE  = 2'd0,
        SEV_ESC   = 2'd1,
        SEV_SCRAP = 2'd2
    } sev_e;

    // Enable bit positions.
    localparam int EN_TEST   = 0;
    localparam int EN_HWDBG  = 1;
    localparam int EN_NVMDBG = 2;
    localparam int EN_CPU    = 3;
    localparam int EN_KEY    = 4;
    localparam int EN_SEED   = 5;
    localparam int EN_ESC    = 6;
    localparam int EN_CHKBYP = 7;

    // Maps a raw stage code to a legal stage; anything unknown becomes scrap.
    function automatic lc_state_e sanitize_stage(logic [STAGE_W-1:0] raw);
        lc_state_e s;
        case (raw)
            4'h1:    s = ST_TEST_UNLK;
            4'h2:    s = ST_DEV;
            4'h3:    s = ST_PROD;
            4'h4:    s = ST_RMA;
            4'h5:    s = ST_TEST_LOCK;
            default: s = ST_SCRAP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lc_esc_tracker.sv
// Sticky escalation severity tracker.
// Finds the highest asserted escalation line and raises the held severity,
// never lowering it until reset. Levels below ESC_LVL_ESCALATE are ignored.
// Assumes ESC_LVL_ESCALATE < ESC_LVL_SCRAP <= NUM_ESC.
module lc_esc_tracker
    import lc_resp_pkg::*;
#(
    parameter int NUM_ESC          = 3,
    parameter int ESC_LVL_ESCALATE = 2,
    parameter int ESC_LVL_SCRAP    = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_ESC-1:0] esc_i,
    output sev_e               sev_q,
    output sev_e               sev_d
);

    localparam int LVL_W = $clog2(NUM_ESC + 1);

    logic [LVL_W-1:0] level;

    // Priority encode: the highest asserted line sets the level (0 = none).
    always_comb begin
        level = '0;
        for (int i = 0; i < NUM_ESC; i++) begin
            if (esc_i[i]) level = LVL_W'(i + 1);
        end
    end

    // Next severity: only ever moves upwards.
    always_comb begin
        sev_d = sev_q;
        if (sev_q == SEV_SCRAP || int'(level) >= ESC_LVL_SCRAP) begin
            sev_d = SEV_SCRAP;
        end else if (int'(level) >= ESC_LVL_ESCALATE) begin
            sev_d = SEV_ESC;
        end
    end

    // Severity register, cleared only by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sev_q <= SEV_NONE;
        else         sev_q <= sev_d;
    end

endmodule

// File: rtl/lc_en_decoder.sv
// Combinational decoder from (stage, severity) to reported state and enables.
// Scrap, whether loaded or escalated into, keeps only escalate and
// check-bypass. Escalate keeps the stage's CPU enable and adds those two.
module lc_en_decoder
    import lc_resp_pkg::*;
(
    input  lc_state_e         stage,
    input  sev_e              sev,
    output lc_state_e         state,
    output logic [NUM_EN-1:0] en
);

    logic [NUM_EN-1:0] base_en;

    // Per-stage enable set before any escalation.
    always_comb begin
        base_en = '0;
        case (stage)
            ST_TEST_UNLK: begin
                base_en[EN_TEST]  = 1'b1;
                base_en[EN_HWDBG] = 1'b1;
                base_en[EN_CPU]   = 1'b1;
            end
            ST_DEV: begin
                base_en[EN_HWDBG]  = 1'b1;
                base_en[EN_NVMDBG] = 1'b1;
                base_en[EN_CPU]    = 1'b1;
                base_en[EN_KEY]    = 1'b1;
                base_en[EN_SEED]   = 1'b1;
            end
            ST_PROD: begin
                base_en[EN_CPU]  = 1'b1;
                base_en[EN_KEY]  = 1'b1;
                base_en[EN_SEED] = 1'b1;
            end
            ST_RMA: begin
                base_en[EN_TEST]   = 1'b1;
                base_en[EN_HWDBG]  = 1'b1;
                base_en[EN_NVMDBG] = 1'b1;
                base_en[EN_CPU]    = 1'b1;
                base_en[EN_KEY]    = 1'b1;
                base_en[EN_SEED]   = 1'b1;
            end
            default: base_en = '0;
        endcase
    end

    // Apply severity on top of the stage decode.
    always_comb begin
        en    = base_en;
        state = stage;
        if (sev == SEV_SCRAP || stage == ST_SCRAP) begin
            state          = ST_SCRAP;
            en             = '0;
            en[EN_ESC]     = 1'b1;
            en[EN_CHKBYP]  = 1'b1;
        end else if (sev == SEV_ESC) begin
            state          = ST_ESCALATE;
            en             = '0;
            en[EN_CPU]     = base_en[EN_CPU];
            en[EN_ESC]     = 1'b1;
            en[EN_CHKBYP]  = 1'b1;
        end
    end

endmodule

// File: rtl/lc_esc_responder.sv
// Lifecycle escalation responder top.
// Loads the stage from stage_i while reset is low, tracks sticky escalation,
// and drives registered state and enable outputs. Enables are zero in reset.
module lc_esc_responder
    import lc_resp_pkg::*;
#(
    parameter int NUM_ESC          = 3,
    parameter int ESC_LVL_ESCALATE = 2,
    parameter int ESC_LVL_SCRAP    = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_ESC-1:0] esc_i,
    input  logic [STAGE_W-1:0] stage_i,
    output logic [STAGE_W-1:0] state_o,
    output logic [NUM_EN-1:0]  en_o
);

    lc_state_e         stage_q;
    sev_e              sev_q;
    sev_e              sev_d;
    lc_state_e         state_d;
    logic [NUM_EN-1:0] en_d;
    lc_state_e         state_q;
    logic [NUM_EN-1:0] en_q;

    lc_esc_tracker #(
        .NUM_ESC          (NUM_ESC),
        .ESC_LVL_ESCALATE (ESC_LVL_ESCALATE),
        .ESC_LVL_SCRAP    (ESC_LVL_SCRAP)
    ) u_tracker (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .esc_i  (esc_i),
        .sev_q  (sev_q),
        .sev_d  (sev_d)
    );

    lc_en_decoder u_decoder (
        .stage (stage_q),
        .sev   (sev_d),
        .state (state_d),
        .en    (en_d)
    );

    // Stage register: loaded from stage_i only while reset is held.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q <= sanitize_stage(stage_i);
    end

    // Output registers: state follows the loaded stage in reset, enables stay off.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= sanitize_stage(stage_i);
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
        end
    end

    assign state_o = state_q;
    assign en_o    = en_q;

endmodule

// File: rtl/lc_esc_responder_chk.sv
// Property checker for the lifecycle escalation responder, bound to the top.
// armed goes high one cycle after reset release so that the first
// post-reset decode is not mistaken for an escalation effect.
module lc_esc_responder_chk #(
    parameter int NUM_ESC          = 3,
    parameter int ESC_LVL_ESCALATE = 2,
    parameter int ESC_LVL_SCRAP    = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_ESC-1:0] esc_i,
    input logic [3:0]         state_o,
    input logic [7:0]         en_o
);

    logic armed;

    // Marks that at least one post-reset update has happened.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) armed <= 1'b0;
        else         armed <= 1'b1;
    end

    logic low_only;
    assign low_only = (|esc_i) && ((esc_i >> (ESC_LVL_ESCALATE - 1)) == '0);

    // R4: first severity alone leaves state and enables untouched
    assert_lvl1_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        low_only |=> ($stable(state_o) && $stable(en_o)));

    // R5: second severity yields escalate or scrap, with escalate enable on
    assert_lvl2_escalates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc_i[ESC_LVL_ESCALATE-1] |=> (en_o[6] && (state_o == 4'hA || state_o == 4'hF)));

    // R5: the escalate state always carries check-bypass
    assert_esc_chkbyp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 4'hA) |-> (en_o[7] && en_o[6]));

    // R6: third severity yields scrap with the CPU enable off
    assert_lvl3_scrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc_i[ESC_LVL_SCRAP-1] |=> (state_o == 4'hF && !en_o[3]));

    // R6: scrap decodes to escalate and check-bypass only
    assert_scrap_enables_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (state_o == 4'hF) |-> (en_o == 8'hC0));

    // R7: scrap never leaves without reset
    assert_scrap_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (state_o == 4'hF) |=> (state_o == 4'hF));

    // R7: escalate only moves on to scrap
    assert_esc_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (state_o == 4'hA) |=> (state_o == 4'hA || state_o == 4'hF));

endmodule

bind lc_esc_responder lc_esc_responder_chk #(
    .NUM_ESC          (NUM_ESC),
    .ESC_LVL_ESCALATE (ESC_LVL_ESCALATE),
    .ESC_LVL_SCRAP    (ESC_LVL_SCRAP)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .esc_i   (esc_i),
    .state_o (state_o),
    .en_o    (en_o)
);

// File: tb/test_lc_esc_responder.sv
// Directed bench for the lifecycle escalation responder.
module test_lc_esc_responder;

    localparam int CLK_PERIOD = 10;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] esc_i = 3'b000;
    logic [3:0] stage_i = 4'h2;
    logic [3:0] state_o;
    logic [7:0] en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    lc_esc_responder i_lc_esc_responder (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .esc_i   (esc_i),
        .stage_i (stage_i),
        .state_o (state_o),
        .en_o    (en_o)
    );

    // Expected stage decode per the requirement table.
    function automatic logic [7:0] exp_en(input logic [3:0] code);
        case (code)
            4'h1:    return 8'h0B;
            4'h2:    return 8'h3E;
            4'h3:    return 8'h38;
            4'h4:    return 8'h3F;
            4'h5:    return 8'h00;
            default: return 8'hC0;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] st, input logic [3:0] st_exp,
                         input logic [7:0] en, input logic [7:0] en_exp);
        checks++;
        if (st !== st_exp || en !== en_exp) begin
            errors++;
            $display("FAIL %s: state=%h en=%h expected state=%h en=%h", req, st, en, st_exp, en_exp);
        end
    endtask

    // Resets with a stage code, checks reset values and the first decode.
    task automatic do_reset(input logic [3:0] code, input logic [3:0] st_exp, input string req);
        @(negedge clk_i);
        rst_ni = 1'b0; esc_i = 3'b000; stage_i = code;
        @(negedge clk_i); @(negedge clk_i);
        check("R1 reset load", state_o, st_exp, en_o, 8'h00);
        rst_ni = 1'b1;
        stage_i = ~code;   // R1: ignored after release
        @(negedge clk_i);
        check(req, state_o, st_exp, en_o, exp_en(st_exp));
        stage_i = 4'h4;
        @(negedge clk_i);
        check("R1 stage_i ignored", state_o, st_exp, en_o, exp_en(st_exp));
    endtask

    // First severity only: nothing changes.
    task automatic t_lvl1(input logic [3:0] st_exp);
        esc_i = 3'b001;
        repeat (3) @(negedge clk_i);
        check("R4 first severity ignored", state_o, st_exp, en_o, exp_en(st_exp));
        esc_i = 3'b000;
        @(negedge clk_i);
    endtask

    // Second severity: escalate state, CPU copied, sticky after drop.
    task automatic t_lvl2(input logic [3:0] st_prev, input logic [7:0] en_prev, input logic cpu);
        esc_i = 3'b010;
        check("R8 no change before edge", state_o, st_prev, en_o, en_prev);
        @(negedge clk_i);
        check("R5 escalate", state_o, 4'hA, en_o, {2'b11, 2'b00, cpu, 3'b000});
        esc_i = 3'b000;
        repeat (4) @(negedge clk_i);
        check("R7 escalate sticky", state_o, 4'hA, en_o, {2'b11, 2'b00, cpu, 3'b000});
    endtask

    // Third severity: scrap, sticky, later second severity has no effect.
    task automatic t_lvl3(input logic [3:0] st_prev, input logic [7:0] en_prev);
        esc_i = 3'b100;
        check("R8 no change before edge", state_o, st_prev, en_o, en_prev);
        @(negedge clk_i);
        check("R6 scrap", state_o, 4'hF, en_o, 8'hC0);
        esc_i = 3'b000;
        repeat (4) @(negedge clk_i);
        check("R7 scrap sticky", state_o, 4'hF, en_o, 8'hC0);
        esc_i = 3'b010;
        repeat (2) @(negedge clk_i);
        check("R6 second severity in scrap", state_o, 4'hF, en_o, 8'hC0);
        esc_i = 3'b000;
    endtask

    // Second and third severity together: third wins.
    task automatic t_both;
        esc_i = 3'b110;
        @(negedge clk_i);
        check("R6 third over second", state_o, 4'hF, en_o, 8'hC0);
        esc_i = 3'b000;
        @(negedge clk_i);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R2: every legal stage decodes to its table value
        do_reset(4'h1, 4'h1, "R2 unlocked test");
        do_reset(4'h3, 4'h3, "R2 production");
        do_reset(4'h4, 4'h4, "R2 RMA");
        do_reset(4'h5, 4'h5, "R2 locked test");
        do_reset(4'h2, 4'h2, "R2 development");
        t_lvl1(4'h2);
        t_lvl2(4'h2, 8'h3E, 1'b1);
        t_lvl3(4'hA, 8'hC8);
        // Locked test keeps CPU off in escalate
        do_reset(4'h5, 4'h5, "R2 locked test");
        t_lvl2(4'h5, 8'h00, 1'b0);
        // Production straight to scrap
        do_reset(4'h3, 4'h3, "R2 production");
        t_lvl3(4'h3, 8'h38);
        do_reset(4'h4, 4'h4, "R2 RMA");
        t_both();
        // R3: illegal and escalate codes load as scrap
        do_reset(4'h7, 4'hF, "R3 invalid stage");
        do_reset(4'hA, 4'hF, "R3 escalate code as stage");
        do_reset(4'hF, 4'hF, "R3 scrap stage");
        do_reset(4'h0, 4'hF, "R3 zero stage");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule